// File: doc/BRIEF.md
# Switched-Capacitor SAR Conversion Sequencer

This block is the digital sequencer for a successive-approximation converter whose DAC is a binary-weighted capacitor array. The array holds NBITS weighted capacitors plus one spare capacitor equal to the smallest one. After a start pulse, the sequencer runs a fixed series of phases:

- It empties the array.
- It connects every bottom plate to the analog input.
- It isolates the array.
- It resolves one bit per clock, most significant bit first, from a one-bit comparator decision.

At the end it publishes the code together with a one-cycle completion strobe.

Each capacitor has its own three one-hot switch lines: input, ground and reference. Capacitor index i carries weight 2^i for i in 0..NBITS-1, and index NBITS is the spare unit capacitor. During a bit step the capacitor under test is placed on the reference. A comparator reading of 1 makes that bit 1 and returns the capacitor to ground. A reading of 0 makes the bit 0 and keeps the capacitor on the reference for the rest of the conversion. The discharge and sample phases each last a programmable number of cycles, and a programmed zero counts as one cycle.

Top module: `sar_cap_seq`

## Requirements
- R1: After reset, and whenever idle, every capacitor is on ground. In that state `discharge_o`, `hold_o`, `busy_o` and `eoc_o` are low, and `result_o` is zero.
- R2: A start begins the phases in this fixed order:
  - discharge for D' = max(`dis_len_i`,1) cycles, with `discharge_o` high and all capacitors on ground;
  - sample for S' = max(`smp_len_i`,1) cycles, with all NBITS+1 capacitors on input;
  - exactly one hold cycle, with `hold_o` high and no capacitor on the reference.
- R3: In every cycle, each capacitor has exactly one of its three switch lines active.
- R4: Conversion takes exactly NBITS cycles, one per bit, with `hold_o` high throughout. Capacitor NBITS-1 is tested first, then each lower index in turn. The capacitor under test is on the reference during its step, and it is the lowest-index weighted capacitor on the reference.
- R5: A comparator value of 1 during a step makes that bit 1, and the tested capacitor is on ground from the next cycle on. A value of 0 makes the bit 0, and the capacitor stays on the reference.
- R6: The spare capacitor (index NBITS) is never on the reference, and it sits on ground through hold and conversion.
- R7: With an ideal comparator, the result equals the input code, with bit NBITS-1 as MSB. For a 3-bit array at about 0.7 of full scale, the result is binary 101.
- R8: `eoc_o` rises on the (D'+S'+NBITS+1)-th edge after the edge that samples `start_i`. It stays high for exactly one cycle, and `result_o` takes the new code on the same edge.
- R9: `busy_o` is high from the edge that samples the start until the edge that raises `eoc_o`, and it is low while `eoc_o` is high.
- R10: A `start_i` pulse seen while busy is ignored. Timing and result of the running conversion are unchanged, and no new conversion follows it.
- R11: `result_o` holds its value between completion strobes, whatever the comparator does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request, honoured only when idle |
| cmp_i | input | 1 | Comparator decision for the bit under test |
| dis_len_i | input | CNT_W | Discharge phase length in cycles (0 means 1) |
| smp_len_i | input | CNT_W | Sample phase length in cycles (0 means 1) |
| sw_in_o | output | NBITS+1 | Per-capacitor switch to analog input |
| sw_gnd_o | output | NBITS+1 | Per-capacitor switch to ground |
| sw_ref_o | output | NBITS+1 | Per-capacitor switch to reference |
| discharge_o | output | 1 | Array discharge control |
| hold_o | output | 1 | Hold control, high in hold and conversion |
| busy_o | output | 1 | Conversion in progress |
| eoc_o | output | 1 | One-cycle end-of-conversion strobe |
| result_o | output | NBITS | Converted code |

## Verification
The bench builds two copies of the sequencer.

- An 8-bit copy with 8-bit phase counters runs the full-scale codes, mid-scale neighbours and alternating patterns. It also sweeps zero, minimum and longer discharge and sample lengths, and injects a start pulse in mid-conversion.
- A 3-bit copy checks the small-array case at 0.7 of full scale, where the decision path passes through both keep and drop outcomes in only three steps.

An ideal comparator model decodes the switch lines. It identifies the capacitor under test and the bits already decided, so every switch pattern the sequencer emits is checked through its effect on the answer.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DISCH,
        PH_SAMPLE,
        PH_HOLD,
        PH_CONV
    } phase_e;

    typedef enum logic [1:0] {
        SW_GND = 2'd0,
        SW_IN  = 2'd1,
        SW_REF = 2'd2
    } sw_sel_e;

endpackage

// File: rtl/sar_phase_ctrl.sv
module sar_phase_ctrl
    import sar_seq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] dis_len_i,
    input  logic [CNT_W-1:0] smp_len_i,
    input  logic             conv_last_i,
    output phase_e           phase_o
);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] smp;
    } ctrl_t;

    ctrl_t r_q, r_d;

    // Remaining-cycles value for a phase of programmed length v (0 acts as 1).
    function automatic logic [CNT_W-1:0] first_count(input logic [CNT_W-1:0] v);
        return (v == '0) ? '0 : v - 1'b1;
    endfunction

    always_comb begin
        r_d = r_q;
        unique case (r_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    r_d.phase = PH_DISCH;
                    r_d.cnt   = first_count(dis_len_i);
                    r_d.smp   = first_count(smp_len_i);
                end
            end
            PH_DISCH: begin
                if (r_q.cnt == '0) begin
                    r_d.phase = PH_SAMPLE;
                    r_d.cnt   = r_q.smp;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            PH_SAMPLE: begin
                if (r_q.cnt == '0) begin
                    r_d.phase = PH_HOLD;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            PH_HOLD: begin
                r_d.phase = PH_CONV;
            end
            PH_CONV: begin
                if (conv_last_i) begin
                    r_d.phase = PH_IDLE;
                end
            end
            default: r_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{phase: PH_IDLE, cnt: '0, smp: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign phase_o = r_q.phase;

    // R2: sample ends in exactly one hold cycle, which leads into conversion
    assert_sample_to_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.phase == PH_SAMPLE && r_q.cnt == '0) |=> (r_q.phase == PH_HOLD));
    assert_hold_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.phase == PH_HOLD) |=> (r_q.phase == PH_CONV));
    // R10: no fresh discharge may begin from a later phase
    assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.phase == PH_SAMPLE || r_q.phase == PH_HOLD || r_q.phase == PH_CONV)
        |=> (r_q.phase != PH_DISCH));

endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine
    import sar_seq_pkg::*;
#(
    parameter int NBITS = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  phase_e           phase_i,
    input  logic             cmp_i,
    output logic [IDX_W-1:0] step_o,
    output logic [NBITS-1:0] bits_o,
    output logic [NBITS-1:0] result_o,
    output logic             eoc_o,
    output logic             last_o
);

    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NBITS - 1);

    typedef struct packed {
        logic [IDX_W-1:0] step;
        logic [NBITS-1:0] bits;
        logic [NBITS-1:0] result;
        logic             eoc;
    } eng_t;

    eng_t r_q, r_d;

    always_comb begin
        r_d     = r_q;
        r_d.eoc = 1'b0;
        if (phase_i == PH_HOLD) begin
            r_d.step = TOP_IDX;
            r_d.bits = '0;
        end else if (phase_i == PH_CONV) begin
            r_d.bits[r_q.step] = cmp_i;
            if (r_q.step == '0) begin
                r_d.result = r_d.bits;
                r_d.eoc    = 1'b1;
            end else begin
                r_d.step = r_q.step - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{step: '0, bits: '0, result: '0, eoc: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign step_o   = r_q.step;
    assign bits_o   = r_q.bits;
    assign result_o = r_q.result;
    assign eoc_o    = r_q.eoc;
    assign last_o   = (phase_i == PH_CONV) && (r_q.step == '0);

    // R4: search starts at the top capacitor and walks down one index per cycle
    assert_msb_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i == PH_HOLD) |=> (r_q.step == TOP_IDX));
    assert_step_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i == PH_CONV && r_q.step != '0) |=> (r_q.step == $past(r_q.step) - 1'b1));
    // R5: the decided bit equals the comparator value of its step
    assert_decision_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i == PH_CONV) |=> (r_q.bits[$past(r_q.step)] == $past(cmp_i)));
    // R8: completion strobe lasts one cycle
    assert_eoc_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.eoc |=> !r_q.eoc);
    // R11: result only moves together with the strobe
    assert_result_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.eoc |-> $stable(r_q.result));

endmodule

// File: rtl/sar_switch_map.sv
module sar_switch_map
    import sar_seq_pkg::*;
#(
    parameter int NBITS = 8,
    parameter int IDX_W = 3
) (
    input  phase_e           phase_i,
    input  logic [IDX_W-1:0] step_i,
    input  logic [NBITS-1:0] bits_i,
    output logic [NBITS:0]   sw_in_o,
    output logic [NBITS:0]   sw_gnd_o,
    output logic [NBITS:0]   sw_ref_o
);

    localparam int NCAP = NBITS + 1;

    logic [1:0] sel [NCAP];

    // Weighted capacitors: test cap on reference, decided zeros stay there.
    for (genvar i = 0; i < NBITS; i++) begin : g_cap
        always_comb begin
            unique case (phase_i)
                PH_SAMPLE: sel[i] = SW_IN;
                PH_CONV: begin
                    if (step_i == IDX_W'(i)) begin
                        sel[i] = SW_REF;
                    end else if (IDX_W'(i) > step_i) begin
                        sel[i] = bits_i[i] ? SW_GND : SW_REF;
                    end else begin
                        sel[i] = SW_GND;
                    end
                end
                default: sel[i] = SW_GND;
            endcase
        end
    end

    // Spare unit capacitor: only ever on input or ground.
    always_comb begin
        sel[NBITS] = (phase_i == PH_SAMPLE) ? SW_IN : SW_GND;
    end

    for (genvar c = 0; c < NCAP; c++) begin : g_dec
        assign sw_in_o[c]  = (sel[c] == SW_IN);
        assign sw_gnd_o[c] = (sel[c] == SW_GND);
        assign sw_ref_o[c] = (sel[c] == SW_REF);
    end

endmodule

// File: rtl/sar_cap_seq.sv
module sar_cap_seq
    import sar_seq_pkg::*;
#(
    parameter int NBITS = 8,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             cmp_i,
    input  logic [CNT_W-1:0] dis_len_i,
    input  logic [CNT_W-1:0] smp_len_i,
    output logic [NBITS:0]   sw_in_o,
    output logic [NBITS:0]   sw_gnd_o,
    output logic [NBITS:0]   sw_ref_o,
    output logic             discharge_o,
    output logic             hold_o,
    output logic             busy_o,
    output logic             eoc_o,
    output logic [NBITS-1:0] result_o
);

    localparam int IDX_W = (NBITS > 1) ? $clog2(NBITS) : 1;
    localparam int NCAP  = NBITS + 1;

    phase_e           phase;
    logic [IDX_W-1:0] step;
    logic [NBITS-1:0] bits;
    logic             conv_last;

    sar_phase_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .dis_len_i   (dis_len_i),
        .smp_len_i   (smp_len_i),
        .conv_last_i (conv_last),
        .phase_o     (phase)
    );

    sar_bit_engine #(.NBITS(NBITS), .IDX_W(IDX_W)) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase_i  (phase),
        .cmp_i    (cmp_i),
        .step_o   (step),
        .bits_o   (bits),
        .result_o (result_o),
        .eoc_o    (eoc_o),
        .last_o   (conv_last)
    );

    sar_switch_map #(.NBITS(NBITS), .IDX_W(IDX_W)) u_map (
        .phase_i  (phase),
        .step_i   (step),
        .bits_i   (bits),
        .sw_in_o  (sw_in_o),
        .sw_gnd_o (sw_gnd_o),
        .sw_ref_o (sw_ref_o)
    );

    assign discharge_o = (phase == PH_DISCH);
    assign hold_o      = (phase == PH_HOLD) || (phase == PH_CONV);
    assign busy_o      = (phase != PH_IDLE);

    // R3: one switch per capacitor at all times
    for (genvar c = 0; c < NCAP; c++) begin : g_chk
        assert_cap_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $countones({sw_in_o[c], sw_gnd_o[c], sw_ref_o[c]}) == 1);
    end

    // R6: spare capacitor never reaches the reference
    assert_spare_no_ref_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_ref_o[NBITS]);
    assert_spare_gnd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hold_o |-> sw_gnd_o[NBITS]);
    // R2: discharge grounds the whole array
    assert_discharge_grounds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        discharge_o |-> (&sw_gnd_o));
    // R9: busy is already clear when the strobe shows
    assert_busy_clear_eoc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_o |-> !busy_o);
    // R1: idle array is fully grounded with controls low
    assert_idle_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> ((&sw_gnd_o) && !discharge_o && !hold_o));

endmodule

// File: tb/sar_cap_seq_test.sv
module sar_cap_seq_test;

    localparam int NB  = 8;
    localparam int CW  = 8;
    localparam int NB3 = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    // 8-bit instance
    logic          start = 1'b0;
    logic          cmp;
    logic [CW-1:0] dis = '0, smp = '0;
    logic [NB:0]   sw_in, sw_gnd, sw_ref;
    logic          discharge, hold, busy, eoc;
    logic [NB-1:0] result;
    logic [7:0]    vin = '0;

    // 3-bit instance
    logic          start3 = 1'b0;
    logic          cmp3;
    logic [3:0]    dis3 = 4'd1, smp3 = 4'd1;
    logic [NB3:0]  sw_in3, sw_gnd3, sw_ref3;
    logic          discharge3, hold3, busy3, eoc3;
    logic [NB3-1:0] result3;
    logic [7:0]    vin3 = '0;

    sar_cap_seq #(.NBITS(NB), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .cmp_i(cmp),
        .dis_len_i(dis), .smp_len_i(smp),
        .sw_in_o(sw_in), .sw_gnd_o(sw_gnd), .sw_ref_o(sw_ref),
        .discharge_o(discharge), .hold_o(hold), .busy_o(busy),
        .eoc_o(eoc), .result_o(result)
    );

    sar_cap_seq #(.NBITS(NB3), .CNT_W(4)) uut3 (
        .clk(clk), .rst_n(rst_n), .start_i(start3), .cmp_i(cmp3),
        .dis_len_i(dis3), .smp_len_i(smp3),
        .sw_in_o(sw_in3), .sw_gnd_o(sw_gnd3), .sw_ref_o(sw_ref3),
        .discharge_o(discharge3), .hold_o(hold3), .busy_o(busy3),
        .eoc_o(eoc3), .result_o(result3)
    );

    // Ideal comparator: test cap = lowest weighted cap on reference;
    // higher caps on ground are decided ones.
    function automatic logic cmp_model(input logic [7:0] refm, input logic [7:0] gndm,
                                       input logic [7:0] v);
        int t;
        logic [7:0] trial;
        t = -1;
        trial = '0;
        for (int j = 7; j >= 0; j--) if (refm[j]) t = j;
        if (t < 0) return 1'b0;
        for (int j = 7; j >= 0; j--) if (j > t) trial[j] = gndm[j];
        trial[t] = 1'b1;
        return v >= trial;
    endfunction

    assign cmp  = cmp_model(sw_ref[7:0], sw_gnd[7:0], vin);
    assign cmp3 = cmp_model({5'b0, sw_ref3[2:0]}, {5'b0, sw_gnd3[2:0]}, vin3);

    int n_tests = 0;
    int n_fail  = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor of the 8-bit instance's switch outputs
    int m_dis, m_smp, m_hold, m_conv;
    int bad_onehot = 0, bad_spare = 0, bad_order = 0, bad_decide = 0, bad_disgnd = 0;
    int prev_t = -1;
    logic prev_cmp = 1'b0;

    always @(negedge clk) begin
        int t;
        if (rst_n) begin
            for (int c = 0; c <= NB; c++)
                if ($countones({sw_in[c], sw_gnd[c], sw_ref[c]}) != 1) bad_onehot++;
            if (sw_ref[NB]) bad_spare++;
            if (hold && !sw_gnd[NB]) bad_spare++;
            if (discharge) begin
                m_dis++;
                if (!(&sw_gnd)) bad_disgnd++;
            end
            if (&sw_in) m_smp++;
            if (hold && sw_ref[NB-1:0] == '0) m_hold++;
            t = -1;
            for (int j = NB - 1; j >= 0; j--) if (sw_ref[j]) t = j;
            if (hold && t >= 0) begin
                m_conv++;
                if (prev_t < 0) begin
                    if (t != NB - 1) bad_order++;
                end else begin
                    if (t != prev_t - 1) bad_order++;
                    if (prev_cmp ? !sw_gnd[prev_t] : !sw_ref[prev_t]) bad_decide++;
                end
                prev_t = t;
                prev_cmp = cmp;
            end else begin
                prev_t = -1;
            end
        end
    end

    task automatic run_conv(input logic [7:0] code, input int d, input int s, input bit glitch);
        int cnt, busy_bad, dp, sp;
        dp = (d == 0) ? 1 : d;
        sp = (s == 0) ? 1 : s;
        @(posedge clk);
        m_dis = 0; m_smp = 0; m_hold = 0; m_conv = 0;
        @(negedge clk);
        vin = code; dis = CW'(d); smp = CW'(s); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cnt = 1;
        busy_bad = 0;
        while (!eoc && cnt < 3000) begin
            if (!busy) busy_bad++;
            start = (glitch && cnt == 4);
            @(negedge clk);
            cnt++;
        end
        start = 1'b0;
        chk(result == code, "R7 result", int'(result), int'(code));
        chk(cnt == dp + sp + NB + 2, "R8 latency", cnt, dp + sp + NB + 2);
        chk(!busy, "R9 busy low at eoc", int'(busy), 0);
        chk(busy_bad == 0, "R9 busy during conversion", busy_bad, 0);
        chk(m_dis == dp, "R2 discharge cycles", m_dis, dp);
        chk(m_smp == sp, "R2 sample cycles", m_smp, sp);
        chk(m_hold == 1, "R2 hold cycles", m_hold, 1);
        chk(m_conv == NB, "R4 bit steps", m_conv, NB);
        @(negedge clk);
        chk(!eoc, "R8 strobe one cycle", int'(eoc), 0);
        if (glitch) begin
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                if (busy) break;
            end
            chk(!busy, "R10 ignored start gives no new conversion", int'(busy), 0);
        end
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk(!busy && !eoc && !discharge && !hold, "R1 controls low", int'({busy, eoc, discharge, hold}), 0);
        chk(result == '0, "R1 result zero", int'(result), 0);
        chk(&sw_gnd, "R1 all grounded", int'(sw_gnd), (1 << (NB + 1)) - 1);
    endtask

    task automatic test_hold_result();
        logic [NB-1:0] keep;
        int moved;
        keep = result;
        moved = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            vin = 8'(k * 37);
            if (result != keep || eoc) moved++;
        end
        chk(moved == 0, "R11 result held while idle", int'(result), int'(keep));
    endtask

    task automatic test_three_bit();
        int cnt;
        @(negedge clk);
        vin3 = 8'd5;   // 0.7 of an 8-step scale, floored
        start3 = 1'b1;
        @(negedge clk);
        start3 = 1'b0;
        cnt = 1;
        while (!eoc3 && cnt < 100) begin
            @(negedge clk);
            cnt++;
        end
        chk(result3 == 3'b101, "R7 three-bit example", int'(result3), 5);
        chk(cnt == 1 + 1 + NB3 + 2, "R8 three-bit latency", cnt, 1 + 1 + NB3 + 2);
    endtask

    initial begin
        #(8 * 150000);
        $display("FAIL watchdog: actual 1 expected 0");
        n_fail++;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        run_conv(8'h5A, 2, 3, 1'b0);
        run_conv(8'h00, 0, 0, 1'b0);
        run_conv(8'hFF, 1, 4, 1'b0);
        run_conv(8'h80, 3, 1, 1'b0);
        run_conv(8'h7F, 2, 2, 1'b1);   // R10 start during conversion
        run_conv(8'h01, 1, 1, 1'b0);
        run_conv(8'hA5, 7, 9, 1'b0);
        test_hold_result();
        test_three_bit();
        chk(bad_onehot == 0, "R3 one switch per cap", bad_onehot, 0);
        chk(bad_spare == 0, "R6 spare cap placement", bad_spare, 0);
        chk(bad_order == 0, "R4 MSB-first order", bad_order, 0);
        chk(bad_decide == 0, "R5 decision switching", bad_decide, 0);
        chk(bad_disgnd == 0, "R2 discharge grounds array", bad_disgnd, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule